// File: doc/BRIEF.md
# Oversampled Serial Receive Bit Recovery

This block turns an asynchronous serial receive line into a stream of recovered bits. A one-cycle enable that pulses at sixteen times the baud rate paces all of its work. Each bit time is split into sixteen phases, numbered RT1 to RT16, and a phase counter tracks where the block is within the current bit. The line first passes through a two-stage synchronizer. While idle, the block looks for a low sample that follows three high samples. It then checks that start bit with three early samples and flags noise when those samples disagree.

Once a start bit is accepted, each data bit takes the majority of three mid-bit samples. The block pulses a valid strobe with the voted value and raises the noise flag if the three samples were not unanimous. Baud-rate mismatch is absorbed by re-aligning the phase counter at two points: at the start-bit edge, and whenever a bit that voted 1 is followed by a falling edge. After a parameter-set number of bits, the block goes back to searching for a start bit. Frame assembly, stop-bit and parity checks belong to the consumer.

Top module: `uart_rx_recover`

## Requirements
- R1: While rst_n is low, and on the first clock after it, bit_valid, bit_data, noise, start_ok and start_bad are all 0.
- R2: The line is delayed by SYNC_STAGES sample-enable ticks. A candidate start edge is a 0 sample whose three preceding samples, all taken while searching, were 1. That 0 sample is phase RT1.
- R3: The start bit is judged on the sample at RT7, using the samples at RT3, RT5 and RT7 (in that order). Patterns 000, 001, 010 and 100 accept it, and start_ok pulses for one clock.
- R4: Patterns 011, 101, 110 and 111 reject it: start_bad pulses for one clock, noise stays 0, and the search restarts needing three fresh 1 samples.
- R5: On an accepted start bit, noise pulses together with start_ok exactly when the pattern is 001, 010 or 100.
- R6: Each data bit is the majority of its RT8, RT9 and RT10 samples. It appears on bit_data, which holds until the next vote, and bit_valid pulses for one clock on the RT10 sample. The first data bit's RT1 follows the start bit's RT16.
- R7: A data bit whose three samples are not all equal pulses noise together with bit_valid.
- R8: After a bit votes 1, a falling edge (a 1 sample then a 0 sample) seen at phase RT1..RT7 of the following bit, or at RT11..RT16 of the voted bit, makes that 0 sample RT1 of the following bit. An edge at RT11..RT16 therefore starts the next bit early.
- R9: After NBITS bits (default 8) have been voted, the block returns to the start search.
- R10: State and outputs change only on clocks with sample_en high, and every strobe lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-clock enable at 16x baud |
| rxd | input | 1 | Asynchronous receive line, idle high |
| bit_data | output | 1 | Last voted data bit |
| bit_valid | output | 1 | One-clock strobe marking a new bit_data |
| noise | output | 1 | One-clock strobe: samples of start or data bit disagreed |
| start_ok | output | 1 | One-clock strobe: start bit accepted |
| start_bad | output | 1 | One-clock strobe: start bit rejected |

## Verification
The hardest situation to reach is the phase re-alignment. The counter moves only when a falling edge lands outside the mid-bit window right after a bit that voted 1, so a nominal-rate transmitter never triggers it. The bench sends frames whose bit length is 15 or 17 samples, rich in 1-to-0 transitions, so edges drift into both the early and the late window. It then compares every strobe against a behavioural model, so a counter that is not re-aligned shows up as a wrong or shifted vote. Each of the eight start-bit patterns is forced by overwriting the samples at RT3, RT5 and RT7.

// File: rtl/rxr_pkg.sv
// Package: shared types and helper functions for the receive bit recovery block.
// Assumes three-sample voting throughout.
package rxr_pkg;

    typedef enum logic [1:0] {
        RX_SEARCH = 2'd0,
        RX_START  = 2'd1,
        RX_DATA   = 2'd2
    } rx_state_e;

    // Number of ones in a three-sample vote.
    function automatic logic [1:0] ones3(input logic [2:0] v);
        return {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[2]};
    endfunction

endpackage

// File: rtl/rxr_sync.sv
// Module: multi-stage synchronizer for the receive line, advancing only on
// sample-enable ticks. Assumes an idle-high line (reset value 1).
module rxr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the line through the stages on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else if (en) begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxr_start_search.sv
// Module: phase-free start edge search. Reports a candidate edge when the
// current sample is 0 and the three previous samples were 1. The history is
// cleared whenever the search is inactive.
module rxr_start_search #(
    parameter int RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic active,
    input  logic sample,
    output logic edge_found
);
    logic [RUN-1:0] hist;

    // Keep the last RUN samples taken while searching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (!active) begin
            hist <= '0;
        end else if (en) begin
            hist <= {hist[RUN-2:0], sample};
        end
    end

    // Candidate edge: full run of ones followed by a zero.
    assign edge_found = active && (&hist) && !sample;
endmodule

// File: rtl/rxr_vote.sv
// Module: three-sample voter. Captures two samples on strobes and combines
// them with the live third sample. Reports the majority and disagreement.
module rxr_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic take_a,
    input  logic take_b,
    input  logic sample,
    output logic maj,
    output logic split
);
    import rxr_pkg::*;

    logic       cap_a;
    logic       cap_b;
    logic [1:0] n_ones;

    // Capture the first two vote samples at their phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= 1'b0;
            cap_b <= 1'b0;
        end else if (en) begin
            if (take_a) cap_a <= sample;
            if (take_b) cap_b <= sample;
        end
    end

    // Count and classify the vote.
    always_comb begin
        n_ones = ones3({cap_a, cap_b, sample});
        maj    = (n_ones >= 2'd2);
        split  = (n_ones != 2'd0) && (n_ones != 2'd3);
    end
endmodule

// File: rtl/uart_rx_recover.sv
// Module: top of the oversampled receive bit recovery. Runs the start search,
// start verification, data voting and phase re-alignment. Assumes sample_en is
// a one-clock pulse at OSR times the baud rate; all state moves only on it.
module uart_rx_recover #(
    parameter int NBITS       = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic rxd,
    output logic bit_data,
    output logic bit_valid,
    output logic noise,
    output logic start_ok,
    output logic start_bad
);
    import rxr_pkg::*;

    localparam int PW = $clog2(OSR + 1);
    localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [PW-1:0] PH_FIRST = PW'(1);
    localparam logic [PW-1:0] PH_NEXT  = PW'(2);
    localparam logic [PW-1:0] PH_LAST  = PW'(OSR);
    localparam logic [PW-1:0] PH_S1    = PW'(OSR / 2 - 5);
    localparam logic [PW-1:0] PH_S2    = PW'(OSR / 2 - 3);
    localparam logic [PW-1:0] PH_S3    = PW'(OSR / 2 - 1);
    localparam logic [PW-1:0] PH_D1    = PW'(OSR / 2);
    localparam logic [PW-1:0] PH_D2    = PW'(OSR / 2 + 1);
    localparam logic [PW-1:0] PH_D3    = PW'(OSR / 2 + 2);
    localparam logic [CW-1:0] BIT_LAST = CW'(NBITS - 1);

    rx_state_e     state;
    logic [PW-1:0] phase;
    logic [CW-1:0] bitcnt;
    logic          prev_one;
    logic          last_s;
    logic          rx_s;
    logic          edge_found;
    logic          searching;
    logic          take_a;
    logic          take_b;
    logic          maj;
    logic          split;
    logic          fall;

    rxr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_en),
        .d     (rxd),
        .q     (rx_s)
    );

    assign searching = (state == RX_SEARCH);

    rxr_start_search #(.RUN(3)) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sample_en),
        .active     (searching),
        .sample     (rx_s),
        .edge_found (edge_found)
    );

    // Select the capture phases for the current vote kind.
    always_comb begin
        take_a = ((state == RX_START) && (phase == PH_S1)) ||
                 ((state == RX_DATA)  && (phase == PH_D1));
        take_b = ((state == RX_START) && (phase == PH_S2)) ||
                 ((state == RX_DATA)  && (phase == PH_D2));
    end

    rxr_vote u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sample_en),
        .take_a (take_a),
        .take_b (take_b),
        .sample (rx_s),
        .maj    (maj),
        .split  (split)
    );

    assign fall = last_s && !rx_s;

    // Main sequencer: search, start check, data voting and re-alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_SEARCH;
            phase     <= PH_FIRST;
            bitcnt    <= '0;
            prev_one  <= 1'b0;
            last_s    <= 1'b1;
            bit_data  <= 1'b0;
            bit_valid <= 1'b0;
            noise     <= 1'b0;
            start_ok  <= 1'b0;
            start_bad <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            noise     <= 1'b0;
            start_ok  <= 1'b0;
            start_bad <= 1'b0;
            if (sample_en) begin
                last_s <= rx_s;
                unique case (state)
                    RX_SEARCH: begin
                        if (edge_found) begin
                            state <= RX_START;
                            phase <= PH_NEXT;
                        end
                    end
                    RX_START: begin
                        if (phase == PH_S3) begin
                            if (!maj) begin
                                start_ok <= 1'b1;
                                noise    <= split;
                                phase    <= phase + PW'(1);
                            end else begin
                                start_bad <= 1'b1;
                                state     <= RX_SEARCH;
                                phase     <= PH_FIRST;
                            end
                        end else if (phase == PH_LAST) begin
                            state    <= RX_DATA;
                            phase    <= PH_FIRST;
                            bitcnt   <= '0;
                            prev_one <= 1'b0;
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (fall && prev_one && (phase <= PH_S3)) begin
                            phase <= PH_NEXT;
                        end else if (fall && prev_one && (phase > PH_D3)) begin
                            phase  <= PH_NEXT;
                            bitcnt <= bitcnt + CW'(1);
                        end else if (phase == PH_D3) begin
                            bit_valid <= 1'b1;
                            bit_data  <= maj;
                            noise     <= split;
                            prev_one  <= maj;
                            if (bitcnt == BIT_LAST) begin
                                state <= RX_SEARCH;
                                phase <= PH_FIRST;
                            end else begin
                                phase <= phase + PW'(1);
                            end
                        end else if (phase == PH_LAST) begin
                            phase  <= PH_FIRST;
                            bitcnt <= bitcnt + CW'(1);
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                    default: begin
                        state <= RX_SEARCH;
                        phase <= PH_FIRST;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_recover_chk.sv
// Module: port-level property checker for uart_rx_recover, attached by bind.
module uart_rx_recover_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_en,
    input logic bit_data,
    input logic bit_valid,
    input logic noise,
    input logic start_ok,
    input logic start_bad
);
    // R10: strobes last a single clock.
    p_valid_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    p_ok_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !start_ok);
    // R10: a strobe rises only after an enabled tick.
    p_valid_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> $past(sample_en));
    // R10: bit_data changes only after an enabled tick.
    p_data_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_en) |-> $stable(bit_data));
    // R3 R4: a start verdict is one or the other.
    p_verdict_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ok, start_bad, bit_valid}));
    // R4: rejection never carries noise.
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |-> !noise);
    // R5 R7: noise only accompanies an accepted start or a vote.
    p_noise_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        noise |-> (start_ok || bit_valid));
endmodule

bind uart_rx_recover uart_rx_recover_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .bit_data  (bit_data),
    .bit_valid (bit_valid),
    .noise     (noise),
    .start_ok  (start_ok),
    .start_bad (start_bad)
);

// File: tb/uart_rx_recover_tb.sv
// Bench: drives frames and start patterns, compares every clock against a
// behavioural model of the requirements.
module uart_rx_recover_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic rxd = 1'b1;
    logic bit_data, bit_valid, noise, start_ok, start_bad;

    int vectors = 0;
    int errors = 0;
    int cyc = 0;
    bit armed = 0;

    always #2 clk = ~clk;

    uart_rx_recover u_dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
        .bit_data(bit_data), .bit_valid(bit_valid), .noise(noise),
        .start_ok(start_ok), .start_bad(start_bad)
    );

    // Enable: one clock in three.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        sample_en <= ((cyc % 3) == 2);
    end

    // Behavioural model.
    int m1, m2, mlast, mstate, mph, mbit, mprev1, run, x, n;
    int smp[17];
    logic e_bv, e_bd, e_nz, e_ok, e_bad;
    int bv_count = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 1; m2 = 1; mlast = 1; mstate = 0; mph = 1; mbit = 0;
            mprev1 = 0; run = 0;
            e_bv = 0; e_bd = 0; e_nz = 0; e_ok = 0; e_bad = 0;
        end else begin
            e_bv = 0; e_nz = 0; e_ok = 0; e_bad = 0;
            if (sample_en) begin
                x = m2; m2 = m1; m1 = int'(rxd);
                smp[mph] = x;
                if (mstate == 0) begin
                    if (x == 0 && run >= 3) begin mstate = 1; mph = 2; end
                    else run = (x == 1) ? run + 1 : 0;
                end else if (mstate == 1) begin
                    if (mph == 7) begin
                        n = smp[3] + smp[5] + smp[7];
                        if (n <= 1) begin e_ok = 1; e_nz = (n == 1); mph = 8; end
                        else begin e_bad = 1; mstate = 0; run = 0; mph = 1; end
                    end else if (mph == 16) begin
                        mstate = 2; mph = 1; mbit = 0; mprev1 = 0;
                    end else mph++;
                end else begin
                    if (mlast == 1 && x == 0 && mprev1 == 1 && mph <= 7) mph = 2;
                    else if (mlast == 1 && x == 0 && mprev1 == 1 && mph >= 11) begin
                        mph = 2; mbit++;
                    end else if (mph == 10) begin
                        n = smp[8] + smp[9] + smp[10];
                        e_bv = 1; e_bd = (n >= 2); e_nz = (n == 1 || n == 2);
                        mprev1 = int'(e_bd);
                        if (mbit == 7) begin mstate = 0; run = 0; mph = 1; end
                        else mph++;
                    end else if (mph == 16) begin mph = 1; mbit++; end
                    else mph++;
                end
                mlast = x;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk(bit_valid, e_bv,  "R6 R8 R9 R10 bit_valid");
            chk(bit_data,  e_bd,  "R6 R8 bit_data");
            chk(noise,     e_nz,  "R5 R7 noise");
            chk(start_ok,  e_ok,  "R2 R3 start_ok");
            chk(start_bad, e_bad, "R4 start_bad");
            if (bit_valid) bv_count++;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n * 3) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input int blen);
        hold(1'b1, 6);
        hold(1'b0, blen);
        for (int i = 0; i < 8; i++) hold(d[i], blen);
        hold(1'b1, blen + 6);
    endtask

    // Start bit with forced RT3/RT5/RT7 samples, then idle high.
    task automatic start_pat(input logic [2:0] p);
        hold(1'b1, 6);
        hold(1'b0, 2); hold(p[2], 1); hold(1'b0, 1);
        hold(p[1], 1); hold(1'b0, 1); hold(p[0], 1);
        hold(1'b0, 9);
        hold(1'b1, 150);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        // R1: reset state.
        chk(bit_valid, 1'b0, "R1 reset bit_valid");
        chk(start_ok | start_bad | noise | bit_data, 1'b0, "R1 reset strobes");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bit_valid | start_ok | start_bad | noise, 1'b0, "R1 after reset");
        armed = 1;
        // R2: a lone 0 right after reset lacks three ones; a short high gap too.
        hold(1'b0, 3); hold(1'b1, 2); hold(1'b0, 20); hold(1'b1, 10);
        // R6 R9: nominal rate frames.
        bv_count = 0;
        frame(8'hA5, 16);
        chk(bv_count == 8, 1'b1, "R9 eight bits per frame");
        frame(8'h3C, 16);
        frame(8'h00, 16);
        frame(8'hFF, 16);
        // R8: rate mismatch both ways.
        frame(8'h55, 15);
        frame(8'hAA, 17);
        frame(8'h55, 17);
        frame(8'h6D, 15);
        // R3 R4 R5: every start pattern.
        for (int p = 0; p < 8; p++) start_pat(3'(p));
        // R7: noisy data bit (single flipped sample at RT9 of bit 0).
        hold(1'b1, 6); hold(1'b0, 16);
        hold(1'b0, 8); hold(1'b1, 1); hold(1'b0, 7);
        for (int i = 0; i < 7; i++) hold(1'b1, 16);
        hold(1'b1, 20);
        // R10: a glitch of two ones then zero while idle.
        hold(1'b0, 1); hold(1'b1, 2); hold(1'b0, 4); hold(1'b1, 30);
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule